// File: doc/BRIEF.md
# ARINC Receive Word Holding Register

This block sits between a serial ARINC 429 bit decoder and a 16-bit host data bus. When the decoder signals that a full 32-bit word has arrived, the block can check the two label-extension bits (ARINC bits 9 and 10) against a pair of programmed values. A word that passes, or any word when the check is switched off, is latched and an active-low ready flag is raised.

The host reads the latched word as two 16-bit halves, using an active-low read enable and a half select. The ready flag falls back only after both halves have been read, in either order. A read counts only once the enable is released. A new qualifying word replaces unread data and restarts the read tracking. While the enable is inactive, the bus output is driven to zero and its valid flag is low, so a neighbour can merge several such outputs.

Top module: `rx_word_hold`

## Requirements
- R1: After reset, `ready_no` is high, `bus_oe_o` is low and `bus_o` is zero.
- R2: With `filt_en_i` low, every `eos_i` pulse latches `word_i`, and `ready_no` is low from the next clock on.
- R3: With `filt_en_i` high, a word is latched only when ARINC bit 9 (`word_i[8]`) equals `match_i[0]` and ARINC bit 10 (`word_i[9]`) equals `match_i[1]`.
- R4: A word rejected by the filter changes neither the held word nor `ready_no`.
- R5: `ready_no` stays low until both halves have been read. A read of a half is counted on the clock at which `rd_en_ni` is first seen high again, using the `half_sel_i` value sampled while the enable was low. `ready_no` goes high on that clock.
- R6: The two halves may be read in either order.
- R7: A qualifying word that arrives before both halves have been read overwrites the held word and clears the record of halves already read.
- R8: With `half_sel_i`=1, `bus_o[k]` carries ARINC bit 14+k (`word[13+k]`) for k=0..15.
- R9: With `half_sel_i`=0, `bus_o[7:0]` carries ARINC bits 1..8, with bit 1 on `bus_o[7]` and bit 8 on `bus_o[0]`. `bus_o[15:8]` carries ARINC bits 13,12,11,10,9,31,30,32, from bus bit 15 down to bus bit 8.
- R10: `bus_oe_o` equals the inverse of `rd_en_ni`. `bus_o` is zero whenever `rd_en_ni` is high.
- R11: Reading the same half more than once does not clear `ready_no`.
- R12: If a qualifying capture lands on the same clock as a completing read release, the capture wins: `ready_no` stays low and both halves must be read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 32 | Decoded word; ARINC bit n on bit n-1 |
| eos_i | input | 1 | One-cycle strobe: word_i is complete |
| filt_en_i | input | 1 | Enable the label-extension filter |
| match_i | input | 2 | Required values of ARINC bits 10 (bit 1) and 9 (bit 0) |
| rd_en_ni | input | 1 | Host read enable, active low |
| half_sel_i | input | 1 | 0 selects the first half, 1 the second half |
| bus_o | output | 16 | Selected half, zero when not enabled |
| bus_oe_o | output | 1 | High while bus_o is being driven |
| ready_no | output | 1 | Data ready flag, active low |

## Verification
The bench uses the default extension-bit position of 8, so the filter compares ARINC bits 9 and 10. The bench sweeps all four match settings with the filter on and off. Directed sequences cover both read orders, repeated reads of one half, an overwrite between the two halves, rejected words both while data is pending and while idle, and a capture that lands on the releasing read. A randomized phase then mixes strobes, filter settings and reads. A behavioural model checks every cycle.

// File: rtl/rxh_pkg.sv
package rxh_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned HALF_W = BUS_W / 2;

  // first half: label reversed in low byte, ext/status/parity in high byte
  function automatic logic [BUS_W-1:0] fmt_first(input logic [WORD_W-1:0] w);
    logic [BUS_W-1:0] r;
    for (int i = 0; i < HALF_W; i++) r[HALF_W-1-i] = w[i];
    r[15:11] = w[12:8];
    r[10]    = w[30];
    r[9]     = w[29];
    r[8]     = w[31];
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] fmt_second(input logic [WORD_W-1:0] w);
    return w[28:13];
  endfunction
endpackage

// File: rtl/rxh_label_filter.sv
module rxh_label_filter
  import rxh_pkg::*;
#(
  parameter int unsigned EXT_LO = 8
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              eos_i,
  input  logic              en_i,
  input  logic [1:0]        match_i,
  output logic              cap_o
);
  logic hit;
  assign hit   = (word_i[EXT_LO +: 2] == match_i);
  assign cap_o = eos_i & (~en_i | hit);
endmodule

// File: rtl/rxh_hold.sv
module rxh_hold
  import rxh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              rd_en_ni,
  input  logic              sel_i,
  output logic [WORD_W-1:0] word_o,
  output logic              rdy_o
);
  logic [WORD_W-1:0] word_q;
  logic              rdy_q;
  logic [1:0]        done_q;
  logic              rd_q;
  logic              sel_q;
  logic              rise;
  logic [1:0]        done_nx;

  assign rise = rd_en_ni & ~rd_q;

  always_comb begin
    done_nx = done_q;
    if (rise) done_nx[sel_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b1;
      sel_q <= 1'b0;
    end else begin
      rd_q <= rd_en_ni;
      if (!rd_en_ni) sel_q <= sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      rdy_q  <= 1'b0;
      done_q <= 2'b00;
    end else if (cap_i) begin
      word_q <= word_i;
      rdy_q  <= 1'b1;
      done_q <= 2'b00;
    end else begin
      done_q <= done_nx;
      if (&done_nx) rdy_q <= 1'b0;
    end
  end

  assign word_o = word_q;
  assign rdy_o  = rdy_q;

  p_hold_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(word_q));
  p_hold_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !cap_i && !rise) |=> rdy_q);
  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (rdy_q && done_q == 2'b00));
  p_done_from_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !rise) |=> $stable(done_q));
endmodule

// File: rtl/rxh_bus_fmt.sv
module rxh_bus_fmt
  import rxh_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              rd_en_ni,
  input  logic              sel_i,
  output logic [BUS_W-1:0]  bus_o,
  output logic              oe_o
);
  logic [BUS_W-1:0] half;
  assign half  = sel_i ? fmt_second(word_i) : fmt_first(word_i);
  assign oe_o  = ~rd_en_ni;
  assign bus_o = oe_o ? half : '0;
endmodule

// File: rtl/rx_word_hold.sv
module rx_word_hold
  import rxh_pkg::*;
#(
  parameter int unsigned EXT_LO = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              eos_i,
  input  logic              filt_en_i,
  input  logic [1:0]        match_i,
  input  logic              rd_en_ni,
  input  logic              half_sel_i,
  output logic [BUS_W-1:0]  bus_o,
  output logic              bus_oe_o,
  output logic              ready_no
);
  logic              cap;
  logic [WORD_W-1:0] held;
  logic              rdy;

  rxh_label_filter #(.EXT_LO(EXT_LO)) i_filter (
    .word_i (word_i),
    .eos_i  (eos_i),
    .en_i   (filt_en_i),
    .match_i(match_i),
    .cap_o  (cap)
  );

  rxh_hold i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .word_i  (word_i),
    .rd_en_ni(rd_en_ni),
    .sel_i   (half_sel_i),
    .word_o  (held),
    .rdy_o   (rdy)
  );

  rxh_bus_fmt i_fmt (
    .word_i  (held),
    .rd_en_ni(rd_en_ni),
    .sel_i   (half_sel_i),
    .bus_o   (bus_o),
    .oe_o    (bus_oe_o)
  );

  assign ready_no = ~rdy;

  p_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && filt_en_i && word_i[EXT_LO +: 2] != match_i) |=> $stable(held));
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && !filt_en_i) |=> (!ready_no && held == $past(word_i)));
  p_idle_bus_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_ni |-> (bus_o == '0 && !bus_oe_o));
endmodule

// File: tb/test_rx_word_hold.sv
module test_rx_word_hold;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] word = '0;
  logic        eos = 1'b0;
  logic        fen = 1'b0;
  logic [1:0]  mt = 2'b00;
  logic        rd_n = 1'b1;
  logic        sel = 1'b0;
  logic [15:0] bus;
  logic        oe;
  logic        rdy_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_word_hold i_rx_word_hold (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .eos_i(eos),
    .filt_en_i(fen), .match_i(mt), .rd_en_ni(rd_n), .half_sel_i(sel),
    .bus_o(bus), .bus_oe_o(oe), .ready_no(rdy_n)
  );

  // ARINC bit number shown on bus bit 15..0 of the first half
  int first_map [16] = '{13,12,11,10,9,31,30,32,1,2,3,4,5,6,7,8};

  function automatic logic [15:0] exp_half(logic [31:0] w, logic s);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) begin
      if (s) r[b] = w[14 + b - 1];
      else   r[15 - b] = w[first_map[b] - 1];
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [31:0] m_word = '0;
  bit m_rdy = 0, m_d0 = 0, m_d1 = 0, m_prev = 1, m_sel = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = '0; m_rdy = 0; m_d0 = 0; m_d1 = 0; m_prev = 1; m_sel = 0;
    end else begin
      bit rise;
      rise = rd_n && !m_prev;
      if (eos && (!fen || (word[8] == mt[0] && word[9] == mt[1]))) begin
        m_word = word; m_rdy = 1; m_d0 = 0; m_d1 = 0;
      end else if (rise) begin
        if (m_sel) m_d1 = 1; else m_d0 = 1;
        if (m_d0 && m_d1) m_rdy = 0;
      end
      if (!rd_n) m_sel = sel;
      m_prev = rd_n;
    end
    #1;
    if (rst_n && !finished) begin
      check("R5 ready", {31'd0, rdy_n}, {31'd0, !m_rdy});
      check("R10 oe", {31'd0, oe}, {31'd0, !rd_n});
      check("R8/R9 bus", {16'd0, bus}, {16'd0, rd_n ? 16'd0 : exp_half(m_word, sel)});
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [31:0] w, logic f, logic [1:0] m);
    word = w; fen = f; mt = m; eos = 1'b1;
    tick();
    eos = 1'b0;
  endtask

  task automatic read_half(logic s, logic [31:0] w, string req);
    rd_n = 1'b0; sel = s;
    #1 check(req, {16'd0, bus}, {16'd0, exp_half(w, s)});
    tick(2);
    rd_n = 1'b1;
    tick(2);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] wa, wb, wc;
    tick(3);
    check("R1 ready", {31'd0, rdy_n}, 32'd1);
    check("R1 oe", {31'd0, oe}, 32'd0);
    check("R1 bus", {16'd0, bus}, 32'd0);
    rst_n = 1'b1;
    tick(2);

    // R2, R9, R8, R5
    wa = 32'hA5C3_1E69;
    send(wa, 1'b0, 2'b00);
    check("R2 ready low", {31'd0, rdy_n}, 32'd0);
    read_half(1'b0, wa, "R9 first half");
    check("R5 one half read", {31'd0, rdy_n}, 32'd0);
    read_half(1'b1, wa, "R8 second half");
    check("R5 both halves read", {31'd0, rdy_n}, 32'd1);

    // R3 accept, R6 reverse order
    wb = 32'h1357_9A00 | (32'h2 << 8);
    send(wb, 1'b1, 2'b10);
    check("R3 match accepted", {31'd0, rdy_n}, 32'd0);
    read_half(1'b1, wb, "R6 second first");
    check("R6 pending", {31'd0, rdy_n}, 32'd0);
    read_half(1'b0, wb, "R6 first last");
    check("R6 cleared", {31'd0, rdy_n}, 32'd1);

    // R4 reject while idle and while pending
    send(32'hFFFF_FCFF, 1'b1, 2'b11);
    check("R4 reject idle", {31'd0, rdy_n}, 32'd1);
    read_half(1'b1, wb, "R4 held unchanged");
    wc = 32'h0F0F_F1F0;
    send(wc, 1'b1, 2'b01);
    check("R3 accept 01", {31'd0, rdy_n}, 32'd0);
    send(32'h8000_0300, 1'b1, 2'b01);
    check("R4 reject pending", {31'd0, rdy_n}, 32'd0);
    read_half(1'b0, wc, "R4 first half kept");

    // R11 same half twice
    read_half(1'b0, wc, "R11 repeat");
    check("R11 still pending", {31'd0, rdy_n}, 32'd0);
    read_half(1'b1, wc, "R11 second");
    check("R11 cleared", {31'd0, rdy_n}, 32'd1);

    // R7 overwrite resets tracking
    send(wa, 1'b0, 2'b00);
    read_half(1'b0, wa, "R7 old first");
    send(wb, 1'b0, 2'b00);
    read_half(1'b1, wb, "R7 new second");
    check("R7 tracking reset", {31'd0, rdy_n}, 32'd0);
    read_half(1'b0, wb, "R7 new first");
    check("R7 cleared", {31'd0, rdy_n}, 32'd1);

    // R12 capture on completing release
    send(wc, 1'b0, 2'b00);
    read_half(1'b1, wc, "R12 pre");
    rd_n = 1'b0; sel = 1'b0;
    tick(2);
    rd_n = 1'b1; word = wa; eos = 1'b1; fen = 1'b0;
    tick();
    eos = 1'b0;
    check("R12 capture wins", {31'd0, rdy_n}, 32'd0);
    read_half(1'b1, wa, "R12 second");
    check("R12 still pending", {31'd0, rdy_n}, 32'd0);
    read_half(1'b0, wa, "R12 first");
    check("R12 cleared", {31'd0, rdy_n}, 32'd1);

    // R10 idle bus
    check("R10 idle bus", {15'd0, oe, bus}, 32'd0);

    // random mix; model checks each cycle
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) send($urandom, 1'($urandom), 2'($urandom));
      else if (op == 1) begin
        rd_n = 1'b0; sel = 1'($urandom);
        tick($urandom_range(1, 3));
        rd_n = 1'b1;
        eos = 1'($urandom_range(0, 3) == 0); word = $urandom;
        fen = 1'($urandom); mt = 2'($urandom);
        tick();
        eos = 1'b0;
      end else tick($urandom_range(1, 3));
    end
    rd_n = 1'b1;
    tick(2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule